// File: doc/BRIEF.md
# Strobed Asynchronous Bus Master with Ready Stretch

This block lets synchronous logic run single read and write accesses on an asynchronous peripheral bus. The bus has an active-low chip-select, separate active-low read and write strobes, a write-data output enable and an active-high ready line. The peripheral holds ready low to stretch an access. On the local side, a requester presents one request at a time with a valid/ready pair. Each request has a direction bit and a write word. The block answers each request with a one-cycle done pulse. Read data is valid alongside the pulse, and an error flag is raised with the pulse when the access was aborted.

Every bus timing minimum is a parameter counted in clock cycles: chip-select lead before the strobe, the blanking window after the strobe falls, and the write-data hold after the strobe rises. The ready input crosses into the clock domain through a synchroniser. The blanking parameter must cover the peripheral's ready-valid delay plus that synchroniser latency. A ready wait has no fixed length. The strobe stays asserted for as long as the synchronised ready reads low, and a cycle limit aborts the access if ready never returns.

After a write, the peripheral may pull ready low while it absorbs the data. The master does not hold back the next request because of that. It starts the next access at once, and that access's strobe simply waits for ready like any other.

Top module: `async_bus_master`

## Requirements
- R1: Out of reset and between accesses, chip-select and both strobes are high (inactive), the data output enable is low, and the request-ready output is high. The strobes are never low together, and a strobe is never low while chip-select is high.
- R2: After a request is accepted, chip-select goes low in the next cycle. The selected strobe (read strobe when the direction bit is 0, write strobe when it is 1) goes low SETUP_CYC cycles after chip-select. The other strobe stays high throughout.
- R3: Synchronised ready is ignored for BLANK_CYC cycles after the first strobe cycle. With ready held high, the strobe therefore stays low for exactly BLANK_CYC+2 cycles. A ready-low pause that ends early enough to be seen before the blanking window closes costs no extra cycles.
- R4: While ready is low after the blanking window, the strobe stays low. The strobe goes high 3 cycles after ready is raised: SYNC_STAGES (2) cycles of synchroniser delay plus one cycle to act on it.
- R5: A read captures the bus input word in the cycle in which synchronised ready is seen high. The word appears on the read-data output with a done pulse HOLD_CYC cycles after the strobe rises.
- R6: For a write, the output enable is high and the bus output carries the request word from the cycle chip-select falls until HOLD_CYC cycles after the write strobe rises. Chip-select rises in the same cycle as the strobe.
- R7: If synchronised ready stays low for TIMEOUT_CYC consecutive cycles after blanking, the access is aborted and the strobe is released. The done pulse arrives HOLD_CYC cycles later with the error flag high. The error flag is low on accesses that complete normally.
- R8: Request-ready is high in the cycle after a done pulse even when ready is low. An access started then drives its strobe and holds it until ready returns high.
- R9: Request-ready is low from acceptance until the done pulse, so a request held valid starts no second access.
- R10: The done pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access aborted by timeout, valid with rsp_done |
| rsp_rdata | output | DATA_W | Read word, valid with rsp_done |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_doe | output | 1 | Write-data output enable |
| bus_dout | output | DATA_W | Write data toward the bus |
| bus_din | input | DATA_W | Read data from the bus |
| bus_rdy | input | 1 | Peripheral ready, active high, asynchronous |

## Verification
Cycles are counted from the accepting clock edge, with index j meaning the falling edge after the j-th following rising edge. With setup 2, blanking 3, hold 2 and timeout 20, chip-select is due low at j=0, the strobe low at j=2 and high again at j=7, and done at j=9. When ready is raised at index r after blanking, the strobe rises at r+3. A timeout releases the strobe at j=26 and gives done at j=28. Every check samples on falling edges at exactly these indices, and the read input is corrupted as soon as the strobe rises, so a late capture is caught.

// File: rtl/abm_pkg.sv
package abm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CS_SETUP,
        ST_STROBE,
        ST_BLANK,
        ST_WAIT,
        ST_RELEASE
    } abm_state_e;

    function automatic logic strobe_phase(input abm_state_e s);
        return (s == ST_STROBE) || (s == ST_BLANK) || (s == ST_WAIT);
    endfunction

    function automatic logic select_phase(input abm_state_e s);
        return (s == ST_CS_SETUP) || strobe_phase(s);
    endfunction

endpackage

// File: rtl/abm_sync.sv
module abm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/abm_tmo.sv
module abm_tmo #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + W'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/abm_ctrl.sv
module abm_ctrl
    import abm_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int BLANK_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              rdy_s,
    input  logic              tmo_exp,
    output logic              tmo_run,
    input  logic [DATA_W-1:0] bus_din,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              doe,
    output logic [DATA_W-1:0] dout
);
    localparam int MAX_AB = (SETUP_CYC > BLANK_CYC) ? SETUP_CYC : BLANK_CYC;
    localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        abm_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              is_wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic              done;
        logic              cs_n;
        logic              rd_n;
        logic              wr_n;
        logic              doe;
    } regs_t;

    localparam regs_t RST_VAL = '{
        state: ST_IDLE, cnt: '0, is_wr: 1'b0, wdata: '0, rdata: '0,
        err: 1'b0, done: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, doe: 1'b0
    };

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state = ST_CS_SETUP;
                    r_d.cnt   = CNT_W'(SETUP_CYC - 1);
                    r_d.is_wr = req_write;
                    r_d.wdata = req_wdata;
                    r_d.err   = 1'b0;
                end
            end
            ST_CS_SETUP: begin
                if (r_q.cnt == '0) r_d.state = ST_STROBE;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            ST_STROBE: begin
                r_d.state = ST_BLANK;
                r_d.cnt   = CNT_W'(BLANK_CYC - 1);
            end
            ST_BLANK: begin
                if (r_q.cnt == '0) r_d.state = ST_WAIT;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            ST_WAIT: begin
                if (rdy_s) begin
                    r_d.state = ST_RELEASE;
                    r_d.cnt   = CNT_W'(HOLD_CYC - 1);
                    if (!r_q.is_wr) r_d.rdata = bus_din;
                end else if (tmo_exp) begin
                    r_d.state = ST_RELEASE;
                    r_d.cnt   = CNT_W'(HOLD_CYC - 1);
                    r_d.err   = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: r_d = RST_VAL;
        endcase

        // bus pins follow the next state so that they leave a flop directly
        r_d.cs_n = !select_phase(r_d.state);
        r_d.rd_n = !(strobe_phase(r_d.state) && !r_d.is_wr);
        r_d.wr_n = !(strobe_phase(r_d.state) &&  r_d.is_wr);
        r_d.doe  = r_d.is_wr && (r_d.state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign tmo_run   = (r_q.state == ST_WAIT);
    assign done      = r_q.done;
    assign err       = r_q.err;
    assign rdata     = r_q.rdata;
    assign cs_n      = r_q.cs_n;
    assign rd_n      = r_q.rd_n;
    assign wr_n      = r_q.wr_n;
    assign doe       = r_q.doe;
    assign dout      = r_q.wdata;
endmodule

// File: rtl/async_bus_master.sv
module async_bus_master #(
    parameter int DATA_W      = 16,
    parameter int SETUP_CYC   = 1,
    parameter int BLANK_CYC   = 3,
    parameter int HOLD_CYC    = 1,
    parameter int TIMEOUT_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_doe,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_rdy
);
    logic rdy_s;
    logic tmo_run;
    logic tmo_exp;
    logic err_q;

    abm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_rdy),
        .sync_out (rdy_s)
    );

    abm_tmo #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmo_run),
        .expired (tmo_exp)
    );

    abm_ctrl #(
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .BLANK_CYC (BLANK_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rdy_s     (rdy_s),
        .tmo_exp   (tmo_exp),
        .tmo_run   (tmo_run),
        .bus_din   (bus_din),
        .done      (rsp_done),
        .err       (err_q),
        .rdata     (rsp_rdata),
        .cs_n      (bus_cs_n),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .doe       (bus_doe),
        .dout      (bus_dout)
    );

    assign rsp_err = rsp_done && err_q;
endmodule

// File: rtl/abm_chk.sv
module abm_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done,
    input logic bus_cs_n,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic bus_doe,
    input logic rdy_s,
    input logic tmo_exp
);
    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R1
    cs_covers_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> (bus_rd_n && bus_wr_n));

    // R2
    cs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(!bus_cs_n));

    // R4
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_rd_n && bus_wr_n) && !rdy_s && !tmo_exp) |=> !(bus_rd_n && bus_wr_n));

    // R6
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |-> bus_doe);

    // R9
    one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind async_bus_master abm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_doe   (bus_doe),
    .rdy_s     (rdy_s),
    .tmo_exp   (tmo_exp)
);

// File: tb/sim_async_bus_master.sv
module sim_async_bus_master;
    localparam int DW    = 16;
    localparam int SETUP = 2;
    localparam int BLANK = 3;
    localparam int HOLD  = 2;
    localparam int TMO   = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_done;
    logic          rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          bus_cs_n, bus_rd_n, bus_wr_n, bus_doe;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din = '0;
    logic          bus_rdy = 1'b1;

    int checks = 0;
    int fails  = 0;

    int m_acc_ok, m_cs_lo, m_cs_hi, m_stb_lo, m_stb_hi, m_doe_last;
    int m_done, m_err, m_busy_rdy, m_dout_bad, m_wrong_stb;
    logic [DW-1:0] m_rdata;

    always #10 clk = ~clk;

    async_bus_master #(
        .DATA_W(DW), .SETUP_CYC(SETUP), .BLANK_CYC(BLANK),
        .HOLD_CYC(HOLD), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_doe(bus_doe), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_rdy(bus_rdy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Starts at a falling edge. j counts falling edges after the accepting rising edge.
    task automatic run_access(input logic wr, input logic [DW-1:0] wd,
                              input logic [DW-1:0] rv, input int rel_j, input int drop_j);
        m_acc_ok = int'(req_ready);
        m_cs_lo = -1; m_cs_hi = -1; m_stb_lo = -1; m_stb_hi = -1;
        m_doe_last = -1; m_done = -1; m_err = -1;
        m_busy_rdy = 0; m_dout_bad = 0; m_wrong_stb = 0;
        req_valid = 1'b1; req_write = wr; req_wdata = wd; bus_din = rv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int j = 0; j < 200; j++) begin
            if (j > 0) @(negedge clk);
            if (!bus_cs_n && m_cs_lo < 0) m_cs_lo = j;
            if (bus_cs_n && m_cs_lo >= 0 && m_cs_hi < 0) m_cs_hi = j;
            if ((!bus_rd_n || !bus_wr_n) && m_stb_lo < 0) m_stb_lo = j;
            if (bus_rd_n && bus_wr_n && m_stb_lo >= 0 && m_stb_hi < 0) begin
                m_stb_hi = j;
                bus_din = ~rv;
            end
            if (wr ? !bus_rd_n : !bus_wr_n) m_wrong_stb++;
            if (bus_doe) begin
                m_doe_last = j;
                if (bus_dout != wd) m_dout_bad++;
            end
            if (j == rel_j)  bus_rdy = 1'b1;
            if (j == drop_j) bus_rdy = 1'b0;
            if (rsp_done) begin
                m_done  = j;
                m_err   = int'(rsp_err);
                m_rdata = rsp_rdata;
                break;
            end
            if (req_ready) m_busy_rdy++;
        end
    endtask

    task automatic t_reset();
        chk("R1 cs_n idle", int'(bus_cs_n), 1);
        chk("R1 rd_n idle", int'(bus_rd_n), 1);
        chk("R1 wr_n idle", int'(bus_wr_n), 1);
        chk("R1 doe idle", int'(bus_doe), 0);
        chk("R1 req_ready idle", int'(req_ready), 1);
        chk("R10 no done at idle", int'(rsp_done), 0);
    endtask

    task automatic t_read_plain();
        run_access(1'b0, 16'h0000, 16'hA5C3, -1, -1);
        chk("R2 accepted", m_acc_ok, 1);
        chk("R2 cs low index", m_cs_lo, 0);
        chk("R2 strobe low index", m_stb_lo, SETUP);
        chk("R2 write strobe unused on read", m_wrong_stb, 0);
        chk("R3 strobe high index", m_stb_hi, SETUP + BLANK + 2);
        chk("R6 cs rises with strobe", m_cs_hi, m_stb_hi);
        chk("R5 done index", m_done, SETUP + BLANK + 2 + HOLD);
        chk("R5 read data", int'(m_rdata), 16'hA5C3);
        chk("R7 no error", m_err, 0);
        chk("R9 ready low while busy", m_busy_rdy, 0);
        chk("R1 doe low on read", m_doe_last, -1);
        @(negedge clk);
        chk("R10 done one cycle", int'(rsp_done), 0);
        chk("R1 idle after access", int'(bus_cs_n & bus_rd_n & bus_wr_n & ~bus_doe & req_ready), 1);
    endtask

    task automatic t_write_plain();
        req_valid = 1'b0;
        run_access(1'b1, 16'h3C96, 16'h0000, -1, -1);
        chk("R2 write strobe low index", m_stb_lo, SETUP);
        chk("R2 read strobe unused on write", m_wrong_stb, 0);
        chk("R3 write strobe high index", m_stb_hi, SETUP + BLANK + 2);
        chk("R6 dout matches word", m_dout_bad, 0);
        chk("R6 doe last index", m_doe_last, SETUP + BLANK + 1 + HOLD);
        chk("R6 cs rises with strobe", m_cs_hi, m_stb_hi);
        chk("R5 write done index", m_done, SETUP + BLANK + 2 + HOLD);
        @(negedge clk);
    endtask

    task automatic t_read_stall();
        bus_rdy = 1'b0;
        run_access(1'b0, 16'h0000, 16'h1E2D, 10, -1);
        chk("R4 strobe high 3 after ready", m_stb_hi, 13);
        chk("R5 stalled done index", m_done, 13 + HOLD);
        chk("R5 stalled read data", int'(m_rdata), 16'h1E2D);
        chk("R7 no error after stall", m_err, 0);
        @(negedge clk);
    endtask

    task automatic t_read_short();
        bus_rdy = 1'b0;
        run_access(1'b0, 16'h0000, 16'h7788, 3, -1);
        chk("R3 pause inside blanking costs nothing", m_stb_hi, SETUP + BLANK + 2);
        chk("R5 short pause read data", int'(m_rdata), 16'h7788);
        @(negedge clk);
    endtask

    task automatic t_timeout();
        bus_rdy = 1'b0;
        run_access(1'b0, 16'h0000, 16'h4242, -1, -1);
        chk("R7 strobe released at limit", m_stb_hi, SETUP + BLANK + 1 + TMO);
        chk("R7 done index", m_done, SETUP + BLANK + 1 + TMO + HOLD);
        chk("R7 error flag", m_err, 1);
        @(negedge clk);
        chk("R7 error only with done", int'(rsp_err), 0);
        bus_rdy = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_posted();
        run_access(1'b1, 16'hBEEF, 16'h0000, -1, SETUP + BLANK + 2);
        chk("R8 write done with ready dropped", m_done, SETUP + BLANK + 2 + HOLD);
        chk("R8 ready offered while bus ready low", int'(req_ready), 1);
        run_access(1'b0, 16'h0000, 16'hCAFE, 10, -1);
        chk("R8 next access accepted", m_acc_ok, 1);
        chk("R8 strobe driven while ready low", m_stb_lo, SETUP);
        chk("R8 strobe held until ready", m_stb_hi, 13);
        chk("R8 read data after posted write", int'(m_rdata), 16'hCAFE);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_read_plain();
        t_write_plain();
        t_read_stall();
        t_read_short();
        t_timeout();
        t_posted();
        summary();
        $finish;
    end
endmodule